// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block picks the clock setting whose output frequency lies closest to a requested pixel frequency. A one-cycle start pulse hands it a target frequency in hertz and a flag that says whether the output drives a flat panel or a CRT. The block then tries every candidate in a fixed order. A candidate is one of two master clocks, an odd divider and a power-of-two shift. For each candidate it computes a rounded quotient, measures the absolute distance to the target and keeps the closest candidate seen so far.

All quotients come from one shared sequential restoring divider, which produces one quotient bit per cycle. After the last candidate the divider runs once more to give the reported frequency of the winner, this time with plain truncation. The selection and that frequency are then presented together with a one-cycle done pulse, and they stay unchanged until the next search finishes.

Top module: `pcs_search`

## Requirements
- R1: The master clock select output `mclk_sel_o` encodes 0 = 288 MHz and 1 = 336 MHz. The master clock is the outermost loop of the search, and 288 MHz is tried first.
- R2: With `panel_i` low at start, only dividers 1 and 3 are tried. With `panel_i` high, 1, 3 and 5 are tried, in that ascending order. `div_o` is the divider as a 3-bit unsigned value.
- R3: For every clock and divider pair, shifts 0 through 7 are tried in ascending order in the innermost loop. The effective divisor is the divider shifted left by the shift, and `shift_o` is the 3-bit shift.
- R4: Each candidate frequency is the rounded quotient (2·M + D) / (2·D), where M is the master clock in Hz and D is the effective divisor.
- R5: The error is the absolute difference between the candidate and the request. A candidate replaces the held best only when its error is strictly smaller, so on a tie the earlier candidate is kept.
- R6: The held best error starts every search at 999,999,999. If no candidate beats it, the result is 288 MHz, divider 1, shift 0.
- R7: `freq_o` is the chosen master clock divided by the effective divisor with truncation.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The running search finishes with its original request and display flag.
- R9: `busy_o` rises in the cycle after an accepted start and stays high until the search ends. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R10: `mclk_sel_o`, `div_o`, `shift_o` and `freq_o` change only in the cycle `done_o` is high, and they hold their values until the next done.
- R11: After reset, `busy_o`, `done_o`, `mclk_sel_o`, `div_o`, `shift_o` and `freq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a search |
| req_hz_i | input | 32 | Requested frequency in Hz, sampled with start |
| panel_i | input | 1 | 1 = panel (dividers 1, 3, 5), 0 = CRT (dividers 1, 3) |
| busy_o | output | 1 | A search is running |
| done_o | output | 1 | One-cycle pulse: the result is valid |
| mclk_sel_o | output | 1 | Chosen master clock, 0 = 288 MHz, 1 = 336 MHz |
| div_o | output | 3 | Chosen odd divider |
| shift_o | output | 3 | Chosen shift |
| freq_o | output | 32 | Truncated output frequency of the chosen setting |

## Verification
The assertions assume that `start_i` is a pulse and that the request and display flag matter only in the cycle the start is accepted. They do not require the inputs to stay still while a search runs. The stimulus therefore drives start for a single cycle, away from the clock edge. In one case it deliberately fires a second start with a different request and flag in the middle of a search, to exercise the rule that starts are ignored while busy. The random requests span from below the smallest candidate to above the largest. Directed cases cover an exact tie, a request of zero and an all-ones request that no candidate can beat.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int FREQ_W = 32;
  localparam int DIV_W  = 3;
  localparam int SH_W   = 3;
  localparam int DEN_W  = DIV_W + (1 << SH_W);
  localparam int ERR_W  = FREQ_W + 1;
  localparam logic [FREQ_W-1:0] MCLK_BASE_HZ = 32'd288_000_000;
  localparam logic [FREQ_W-1:0] MCLK_STEP_HZ = 32'd48_000_000;
  localparam logic [ERR_W-1:0]  BEST_INIT    = 33'd999_999_999;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_FISSUE, S_FWAIT
  } pcs_state_e;

  function automatic logic [FREQ_W-1:0] mclk_hz(input logic sel);
    return sel ? (MCLK_BASE_HZ + MCLK_STEP_HZ) : MCLK_BASE_HZ;
  endfunction

  // divider index 0,1,2 -> 1,3,5
  function automatic logic [DIV_W-1:0] odd_div(input logic [1:0] idx);
    return {idx, 1'b1};
  endfunction

  function automatic logic [DEN_W-1:0] eff_div(input logic [DIV_W-1:0] dv,
                                               input logic [SH_W-1:0] sh);
    return DEN_W'(dv) << sh;
  endfunction

  function automatic logic [FREQ_W-1:0] rnd_num(input logic [FREQ_W-1:0] m,
                                                input logic [DEN_W-1:0] d);
    return (m << 1) + FREQ_W'(d);
  endfunction

  function automatic logic [FREQ_W-1:0] rnd_den(input logic [DEN_W-1:0] d);
    return FREQ_W'(d) << 1;
  endfunction

  function automatic logic [ERR_W-1:0] abs_err(input logic [FREQ_W-1:0] a,
                                               input logic [FREQ_W-1:0] b);
    logic [ERR_W-1:0] ea, eb;
    ea = {1'b0, a};
    eb = {1'b0, b};
    return (ea >= eb) ? (ea - eb) : (eb - ea);
  endfunction
endpackage

// File: rtl/pcs_seqdiv.sv
module pcs_seqdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         valid,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem_q[W-1:0], quo_q[W-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign quot  = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start && !busy) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcs_walker.sv
module pcs_walker #(
  parameter int SH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic            panel,
  output logic            sel,
  output logic [1:0]      div_idx,
  output logic [SH_W-1:0] sh,
  output logic            last
);
  localparam logic [SH_W-1:0] SH_MAX = '1;

  logic [1:0] div_last;
  logic       sh_wrap, div_wrap;

  assign div_last = panel ? 2'd2 : 2'd1;
  assign sh_wrap  = (sh == SH_MAX);
  assign div_wrap = sh_wrap && (div_idx == div_last);
  assign last     = div_wrap && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= 1'b0;
      div_idx <= '0;
      sh      <= '0;
    end else if (clear) begin
      sel     <= 1'b0;
      div_idx <= '0;
      sh      <= '0;
    end else if (step) begin
      sh <= sh + 1'b1;
      if (sh_wrap) div_idx <= div_wrap ? 2'd0 : div_idx + 2'd1;
      if (div_wrap) sel <= ~sel;
    end
  end
endmodule

// File: rtl/pcs_search.sv
module pcs_search
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] req_hz_i,
  input  logic              panel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mclk_sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [SH_W-1:0]   shift_o,
  output logic [FREQ_W-1:0] freq_o
);
  pcs_state_e        state_q;
  logic [FREQ_W-1:0] req_q;
  logic              panel_q;
  logic [ERR_W-1:0]  best_err;
  logic              best_sel;
  logic [DIV_W-1:0]  best_div;
  logic [SH_W-1:0]   best_sh;

  logic              w_sel, w_last, w_clear, w_step;
  logic [1:0]        w_idx;
  logic [SH_W-1:0]   w_sh;
  logic [DIV_W-1:0]  cand_div;
  logic [DEN_W-1:0]  cand_d, best_d;

  logic              dv_start, dv_busy, dv_valid;
  logic [FREQ_W-1:0] dv_num, dv_den, dv_quot;

  // named events for the checker
  logic              accept, cand_eval, cand_better, final_ready;
  logic [ERR_W-1:0]  cand_err;

  assign accept      = (state_q == S_IDLE) && start_i;
  assign cand_eval   = (state_q == S_WAIT) && dv_valid;
  assign final_ready = (state_q == S_FWAIT) && dv_valid;
  assign cand_err    = abs_err(dv_quot, req_q);
  assign cand_better = cand_eval && (cand_err < best_err);

  assign cand_div = odd_div(w_idx);
  assign cand_d   = eff_div(cand_div, w_sh);
  assign best_d   = eff_div(best_div, best_sh);

  assign w_clear  = accept;
  assign w_step   = cand_eval;
  assign dv_start = (state_q == S_ISSUE) || (state_q == S_FISSUE);

  always_comb begin
    if (state_q == S_FISSUE) begin
      dv_num = mclk_hz(best_sel);
      dv_den = FREQ_W'(best_d);
    end else begin
      dv_num = rnd_num(mclk_hz(w_sel), cand_d);
      dv_den = rnd_den(cand_d);
    end
  end

  pcs_walker #(.SH_W(SH_W)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (w_clear),
    .step   (w_step),
    .panel  (panel_q),
    .sel    (w_sel),
    .div_idx(w_idx),
    .sh     (w_sh),
    .last   (w_last)
  );

  pcs_seqdiv #(.W(FREQ_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(dv_start),
    .num  (dv_num),
    .den  (dv_den),
    .busy (dv_busy),
    .valid(dv_valid),
    .quot (dv_quot)
  );

  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      req_q      <= '0;
      panel_q    <= 1'b0;
      best_err   <= BEST_INIT;
      best_sel   <= 1'b0;
      best_div   <= DIV_W'(1);
      best_sh    <= '0;
      done_o     <= 1'b0;
      mclk_sel_o <= 1'b0;
      div_o      <= '0;
      shift_o    <= '0;
      freq_o     <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          req_q    <= req_hz_i;
          panel_q  <= panel_i;
          best_err <= BEST_INIT;
          best_sel <= 1'b0;
          best_div <= DIV_W'(1);
          best_sh  <= '0;
          state_q  <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (cand_eval) begin
          if (cand_better) begin
            best_err <= cand_err;
            best_sel <= w_sel;
            best_div <= cand_div;
            best_sh  <= w_sh;
          end
          state_q <= w_last ? S_FISSUE : S_ISSUE;
        end
        S_FISSUE: state_q <= S_FWAIT;
        S_FWAIT: if (final_ready) begin
          freq_o     <= dv_quot;
          mclk_sel_o <= best_sel;
          div_o      <= best_div;
          shift_o    <= best_sh;
          done_o     <= 1'b1;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
  import pcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mclk_sel_o,
  input logic [DIV_W-1:0]  div_o,
  input logic [FREQ_W-1:0] freq_o,
  input logic              panel_q,
  input logic [FREQ_W-1:0] req_q,
  input logic [ERR_W-1:0]  best_err,
  input logic              cand_eval,
  input logic [DIV_W-1:0]  cand_div
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8
  ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (panel_q == $past(panel_q) && req_q == $past(req_q)));

  // R5
  best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (best_err <= $past(best_err)));

  // R2
  div_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_eval |-> (cand_div == 3'd1 || cand_div == 3'd3 || (panel_q && cand_div == 3'd5)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(freq_o) && $stable(div_o) && $stable(mclk_sel_o)));
endmodule

bind pcs_search pcs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mclk_sel_o(mclk_sel_o),
  .div_o     (div_o),
  .freq_o    (freq_o),
  .panel_q   (panel_q),
  .req_q     (req_q),
  .best_err  (best_err),
  .cand_eval (cand_eval),
  .cand_div  (cand_div)
);

// File: tb/tb_pcs_search.sv
module tb_pcs_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] req_hz_i = '0;
  logic        panel_i = 1'b0;
  logic        busy_o, done_o, mclk_sel_o;
  logic [2:0]  div_o, shift_o;
  logic [31:0] freq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pcs_search dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_hz_i(req_hz_i),
    .panel_i(panel_i), .busy_o(busy_o), .done_o(done_o),
    .mclk_sel_o(mclk_sel_o), .div_o(div_o), .shift_o(shift_o), .freq_o(freq_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent model of the search (R1..R7)
  function automatic void model(input longint req, input bit panel,
                                output int sel, output int dv, output int sh,
                                output longint f);
    longint best = 999999999;
    sel = 0; dv = 1; sh = 0;
    for (int m = 0; m < 2; m++) begin
      for (int d = 1; d <= (panel ? 5 : 3); d += 2) begin
        for (int s = 0; s < 8; s++) begin
          longint mc = 64'd288000000 + 64'd48000000 * m;
          longint den = longint'(d) << s;
          longint c = (2 * mc + den) / (2 * den);
          longint e = (c > req) ? c - req : req - c;
          if (e < best) begin
            best = e; sel = m; dv = d; sh = s;
          end
        end
      end
    end
    f = (64'd288000000 + 64'd48000000 * sel) / (longint'(dv) << sh);
  endfunction

  task automatic search(input logic [31:0] req, input bit panel, input bit poke);
    int sel, dv, sh, waited;
    longint f;
    model({32'd0, req}, panel, sel, dv, sh, f);
    @(negedge clk);
    start_i = 1'b1; req_hz_i = req; panel_i = panel;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 busy after start", busy_o, 1);
    if (poke) begin
      repeat (200) @(negedge clk);
      start_i = 1'b1; req_hz_i = ~req; panel_i = ~panel;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 done seen", done_o, 1);
    chk("R9 busy low at done", busy_o, 0);
    chk(poke ? "R8 R1 sel" : "R1 sel", mclk_sel_o, sel);
    chk(poke ? "R8 R2 div" : "R2 R5 div", div_o, dv);
    chk(poke ? "R8 R3 shift" : "R3 R4 shift", shift_o, sh);
    chk("R7 freq", freq_o, f);
    @(negedge clk);
    chk("R9 done one cycle", done_o, 0);
    repeat (5) @(negedge clk);
    chk("R10 freq held", freq_o, f);
    chk("R10 div held", div_o, dv);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy_o, 0);
    chk("R11 done", done_o, 0);
    chk("R11 sel", mclk_sel_o, 0);
    chk("R11 div", div_o, 0);
    chk("R11 shift", shift_o, 0);
    chk("R11 freq", freq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    search(32'd40000000, 1'b0, 1'b0);
    search(32'd25175000, 1'b0, 1'b0);
    search(32'd67200000, 1'b1, 1'b0);   // R2 panel-only divider 5
    search(32'd67200000, 1'b0, 1'b0);
    search(32'd156000000, 1'b0, 1'b0);  // R5 tie, earliest kept
    search(32'd0, 1'b1, 1'b0);
    search(32'd0, 1'b0, 1'b0);
    search(32'hFFFFFFFF, 1'b1, 1'b0);   // R6 nothing beats initial error
    search(32'd50000000, 1'b1, 1'b1);   // R8 start ignored while busy
    for (int i = 0; i < 16; i++)
      search($urandom_range(32'd200000, 32'd400000000), 1'($urandom_range(0, 1)), 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule